// File: doc/BRIEF.md
# Weighted Moving-Average Smoothing Filter

This block smooths a stream of signed conversion results. Each accepted sample is combined with the six samples accepted just before it. The newest sample counts twice and each older one counts once, so the weights add up to eight. The total is then scaled down by a three-bit arithmetic right shift. Every accepted input yields one smoothed output on the following clock, with a matching one-cycle valid pulse.

The block is meant to sit directly behind a sample source that raises a strobe whenever a new result is available. A sticky fill flag tells the consumer when the seven-sample window holds real data and not the zeros loaded at reset. Reset empties the history, so the first outputs after reset are computed against a zero-filled window.

Top module: `wma_filter`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `out_valid` is 0, `out_data` is 0 and `fill_ready` is 0.
- R2: For each accepted sample x(n), the output is floor((2·x(n) + x(n−1) + … + x(n−6)) / 8). Samples not yet received since reset count as zero.
- R3: The weighted sum is formed three bits wider than the input and never overflows. Seven full-scale positive samples give +2047 and seven full-scale negative samples give −2048 with the 12-bit default.
- R4: Division rounds toward negative infinity. A lone sample of −1 after reset gives −1, not 0.
- R5: `out_valid` is high on exactly the clock after each clock with `in_valid` high, and low otherwise.
- R6: When `in_valid` is low, `in_data` is ignored: `out_data` holds its value and the history is unchanged, as seen in the next output.
- R7: `fill_ready` rises together with the output of the seventh accepted sample after reset and stays high until the next reset.
- R8: Reset clears the history, so the first output after reset depends only on the new sample.
- R9: A sample stops contributing once seven newer samples have been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: `in_data` holds a new sample this cycle |
| in_data | input | DATA_W | Signed two's-complement sample |
| out_valid | output | 1 | One-cycle pulse marking a new `out_data` |
| out_data | output | DATA_W | Signed smoothed result |
| fill_ready | output | 1 | High once seven samples have been accepted since reset |

## Verification
The assertions assume that `in_valid` and `in_data` are settled at every rising edge and are never unknown while reset is released. They also assume the weights add up to a power of two, which holds for the default six older taps. The bench drives both inputs on the falling edge and leaves them at defined values between samples, including during the idle stretches. In those stretches it deliberately changes `in_data` with the strobe low so that the hold property is exercised.

// File: rtl/wma_pkg.sv
package wma_pkg;
  // Number of older samples in the window; newest sample carries weight two,
  // so total weight is PRIOR_TAPS + 2 and must be a power of two.
  localparam int PRIOR_TAPS = 6;

  function automatic int norm_shift(input int prior);
    return $clog2(prior + 2);
  endfunction
endpackage

// File: rtl/wma_delay_line.sv
module wma_delay_line #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    shift_en,
  input  logic [DATA_W-1:0]       din,
  output logic [DEPTH*DATA_W-1:0] taps_flat
);
  logic [DATA_W-1:0] stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stage[i] <= '0;
        else if (shift_en) stage[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stage[i] <= '0;
        else if (shift_en) stage[i] <= stage[i-1];
      end
    end
    assign taps_flat[i*DATA_W +: DATA_W] = stage[i];
  end
endmodule

// File: rtl/wma_weighted_sum.sv
module wma_weighted_sum #(
  parameter int DATA_W = 12,
  parameter int PRIOR  = 6,
  localparam int SHIFT = wma_pkg::norm_shift(PRIOR),
  localparam int SUM_W = DATA_W + SHIFT
) (
  input  logic [DATA_W-1:0]       cur,
  input  logic [PRIOR*DATA_W-1:0] hist_flat,
  output logic [SUM_W-1:0]        sum_full,
  output logic [SUM_W-1:0]        scaled
);
  function automatic logic signed [SUM_W-1:0] widen(input logic [DATA_W-1:0] v);
    return SUM_W'($signed(v));
  endfunction

  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = widen(cur) + widen(cur);
    for (int i = 0; i < PRIOR; i++) begin
      acc = acc + widen(hist_flat[i*DATA_W +: DATA_W]);
    end
  end

  assign sum_full = acc;
  assign scaled   = acc >>> SHIFT;
endmodule

// File: rtl/wma_fill_tracker.sv
module wma_fill_tracker #(
  parameter int TAPS = 7,
  localparam int CNT_W = $clog2(TAPS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic ready
);
  logic [CNT_W-1:0] seen;
  logic             seen_full;

  assign seen_full = (seen == CNT_W'(TAPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= '0;
      ready <= 1'b0;
    end else if (accept && !seen_full) begin
      seen <= seen + 1'b1;
      if (seen == CNT_W'(TAPS - 1)) ready <= 1'b1;
    end
  end

  a_r7_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

// File: rtl/wma_filter.sv
module wma_filter #(
  parameter int DATA_W = 12,
  parameter int PRIOR  = wma_pkg::PRIOR_TAPS,
  localparam int SHIFT = wma_pkg::norm_shift(PRIOR),
  localparam int SUM_W = DATA_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              fill_ready
);
  logic [PRIOR*DATA_W-1:0] hist_flat;
  logic [SUM_W-1:0]        sum_full;
  logic [SUM_W-1:0]        scaled;
  logic                    scaled_fits;

  wma_delay_line #(.DATA_W(DATA_W), .DEPTH(PRIOR)) i_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
    .din(in_data), .taps_flat(hist_flat)
  );

  wma_weighted_sum #(.DATA_W(DATA_W), .PRIOR(PRIOR)) i_sum (
    .cur(in_data), .hist_flat(hist_flat),
    .sum_full(sum_full), .scaled(scaled)
  );

  wma_fill_tracker #(.TAPS(PRIOR + 1)) i_fill (
    .clk(clk), .rst_n(rst_n), .accept(in_valid), .ready(fill_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= scaled[DATA_W-1:0];
    end
  end

  // Scaled result fits the output when its upper bits are a pure sign extension.
  assign scaled_fits = (&scaled[SUM_W-1:DATA_W-1]) || !(|scaled[SUM_W-1:DATA_W-1]);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> scaled_fits && (sum_full[SUM_W-1] == scaled[SUM_W-1]));
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  a_r7_ready_with_output: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_ready) |-> out_valid);
endmodule

// File: tb/test_wma_filter.sv
module test_wma_filter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;
  logic fill_ready;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // {sample, expected output, expected fill flag}
  localparam int VEC_X   [NV] = '{8, 16, -8, 100, 0, 40, -3, 2047, 7, 1};
  localparam int VEC_Y   [NV] = '{2, 5, 1, 27, 14, 24, 18, 529, 273, 274};
  localparam bit VEC_RDY [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1};

  always #(CLK_PERIOD/2) clk = ~clk;

  wma_filter #(.DATA_W(W)) i_wma_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .fill_ready(fill_ready)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic send(input int x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = W'(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 out_data in reset", int'($signed(out_data)), 0);
    chk("R1 fill_ready in reset", int'(fill_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 fill_ready after reset", int'(fill_ready), 0);
  endtask

  initial begin
    do_reset();

    // R2 R9 R7: table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC_X[i]);
      chk($sformatf("R2 R9 vector %0d out_data", i), int'($signed(out_data)), VEC_Y[i]);
      chk($sformatf("R5 vector %0d out_valid", i), int'(out_valid), 1);
      chk($sformatf("R7 vector %0d fill_ready", i), int'(fill_ready), int'(VEC_RDY[i]));
    end

    // R5 R6: idle with changing data
    for (int k = 0; k < 4; k++) begin
      in_data = W'(-1000 + 300 * k);
      @(negedge clk);
      chk("R5 no valid when idle", int'(out_valid), 0);
      chk("R6 out_data held", int'($signed(out_data)), 274);
    end
    // R6: history untouched -> next output uses x4..x10 window
    send(0);   // 0 + 1+7+2047-3+40+0 = 2092 -> 261
    chk("R6 history unchanged by idle data", int'($signed(out_data)), 261);

    // R3: full scale both ways
    for (int k = 0; k < 7; k++) send(2047);
    chk("R3 positive full scale", int'($signed(out_data)), 2047);
    for (int k = 0; k < 7; k++) send(-2048);
    chk("R3 negative full scale", int'($signed(out_data)), -2048);

    // R8 R4 R7: reset clears history and fill flag
    do_reset();
    send(-1);
    chk("R4 R8 floor of lone -1", int'($signed(out_data)), -1);
    send(-1);  // -2 -1 = -3 -> -1
    chk("R4 floor of -3/8", int'($signed(out_data)), -1);
    for (int k = 0; k < 4; k++) send(0);
    chk("R7 not ready after six", int'(fill_ready), 0);
    send(0);
    chk("R7 ready after seven", int'(fill_ready), 1);
    @(negedge clk);
    chk("R7 ready stays high", int'(fill_ready), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule